// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache on a Shared Bus

This block is a direct-mapped, word-addressed cache that watches a processor-to-memory bus made of a read strobe, a write strobe, an address, write data, returned memory data and one shared acknowledge line. Each line holds one word, a tag and a valid bit. When a read finds its word in the cache, the cache drives the word and its own acknowledge, so the cycle ends well before the slow memory would answer. When a read misses, the cache stays silent, waits for the memory to acknowledge, and keeps the returned word.

Every write is passed through: the memory still performs it and acknowledges it, while the cache copies the written word into the addressed line. The shared acknowledge is modelled as a wired OR of the cache's driver and the memory's acknowledge, so it is low whenever neither drives it. A single-cycle invalidate-all input empties the cache.

The low `IDX_W` address bits pick the line and the remaining high bits are kept as the tag. With `ADDR_W` = 30 and `IDX_W` = 15 the block is a 32K-word cache over a 30-bit word address space; the default `IDX_W` is smaller so that the default build stays light.

Top module: `dm_wt_cache`

## Requirements
- R1: The line index is address bits [IDX_W-1:0] and the tag is bits [ADDR_W-1:IDX_W]; two addresses with the same index and different tags evict each other, so after one is filled the other misses.
- R2: Reset clears every valid bit; the first read of any address after reset is a miss and the cache does not drive acknowledge for it.
- R3: On a read hit the cache acknowledge (`ack_drv` = 1) rises one clock edge after the read is first sampled, is held for as long as `bus_rd` stays high, and falls in the same cycle `bus_rd` falls.
- R4: On a read miss the cache never drives acknowledge; when `mem_ack` is high during the read, `mem_rdata` and the tag are stored in the indexed line and a later read of that address hits with that word.
- R5: While `bus_wr` is high the cache stores `bus_wdata` and the tag in the indexed line and never drives acknowledge; a later read of that address hits and returns the written word.
- R6: `ack_bus` is the OR of the cache's acknowledge and `mem_ack`, and is 0 when neither drives it.
- R7: A cycle with `inval_all` = 1 clears every valid bit in that one edge, taking priority over a fill or write in the same cycle, so all following reads miss.
- R8: Once a read miss has been filled, the cache does not acknowledge the remainder of that same read cycle.
- R9: `rd_oe` is 1 exactly while the cache drives acknowledge, and `rd_data` then carries the hit word; otherwise `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Processor read strobe, address valid |
| bus_wr | input | 1 | Processor write strobe, address and data valid |
| bus_addr | input | ADDR_W | Word address on the bus |
| bus_wdata | input | DATA_W | Write data on the bus |
| mem_ack | input | 1 | Memory's acknowledge onto the shared line |
| mem_rdata | input | DATA_W | Word returned by memory on a read |
| inval_all | input | 1 | Clear every valid bit |
| ack_drv | output | 1 | Cache's enable for its acknowledge driver |
| ack_bus | output | 1 | Resolved shared acknowledge line |
| rd_data | output | DATA_W | Hit word driven by the cache |
| rd_oe | output | 1 | Cache drives the data bus |

## Verification
A hit acknowledge and its word are due one edge after the read is first sampled, and they must drop with no delay when the read strobe falls; the bench drives inputs at the falling edge, reads the hit result at the next falling edge, and checks the release a nanosecond after lowering the strobe. Fills, writes and invalidation take effect at the single edge that samples them, so the bench confirms each one through the hit or miss of the next read transaction. Misses are checked at every falling edge of the wait and again after the fill edge, where any acknowledge from the cache would be an error.

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              inval_all,
  output logic              ack_drv,
  output logic              ack_bus,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_WAIT  = 2'd1;
  localparam logic [1:0] S_DRIVE = 2'd2;
  localparam logic [1:0] S_HOLD  = 2'd3;

  logic [TAG_W-1:0]  tag_mem [LINES];
  logic [DATA_W-1:0] dat_mem [LINES];
  logic [LINES-1:0]  valid;
  logic [1:0]        state, state_nx;
  logic [DATA_W-1:0] data_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit, fill, store, idle;

  assign idx   = bus_addr[IDX_W-1:0];
  assign tag   = bus_addr[ADDR_W-1:IDX_W];
  assign hit   = valid[idx] && (tag_mem[idx] == tag);
  assign idle  = (state == S_IDLE);
  assign fill  = bus_rd && mem_ack && (idle || state == S_WAIT);
  assign store = bus_wr || fill;

  always_ff @(posedge clk) begin
    if (store) begin
      tag_mem[idx] <= tag;
      dat_mem[idx] <= bus_wr ? bus_wdata : mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || inval_all) valid <= '0;
    else if (store)       valid[idx] <= 1'b1;
  end

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:
        if (bus_rd) begin
          if (mem_ack)  state_nx = S_HOLD;
          else if (hit) state_nx = S_DRIVE;
          else          state_nx = S_WAIT;
        end
      S_WAIT:
        if (!bus_rd)      state_nx = S_IDLE;
        else if (mem_ack) state_nx = S_HOLD;
      default:
        if (!bus_rd) state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (idle && bus_rd && hit) data_q <= dat_mem[idx];
  end

  assign ack_drv = (state == S_DRIVE) && bus_rd;
  assign ack_bus = ack_drv || mem_ack;
  assign rd_oe   = ack_drv;
  assign rd_data = rd_oe ? data_q : '0;
endmodule

module dm_wt_cache_chk #(
  parameter int LINES = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             mem_ack,
  input logic             inval_all,
  input logic             ack_drv,
  input logic             hit,
  input logic [1:0]       state,
  input logic [LINES-1:0] valid
);
  p_ack_needs_read_r3: assert property (@(posedge clk) disable iff (rst)
    ack_drv |-> bus_rd);
  p_ack_held_r3: assert property (@(posedge clk) disable iff (rst)
    ack_drv |=> (ack_drv || !bus_rd));
  p_hit_ack_next_r3: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && bus_rd && hit && !mem_ack) |=> (ack_drv || !bus_rd));
  p_miss_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && bus_rd && !hit) |=> !ack_drv);
  p_no_reack_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && mem_ack && !ack_drv) |=> !ack_drv);
  p_write_silent_r5: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> !ack_drv);
  p_reset_clear_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid == '0));
  p_flush_clear_r7: assert property (@(posedge clk) disable iff (rst)
    inval_all |=> (valid == '0));
endmodule

bind dm_wt_cache dm_wt_cache_chk #(.LINES(LINES)) i_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .mem_ack(mem_ack),
  .inval_all(inval_all), .ack_drv(ack_drv), .hit(hit), .state(state),
  .valid(valid)
);

// File: tb/test_dm_wt_cache.sv
`timescale 1ns/1ps
module test_dm_wt_cache;
  localparam int AW = 8, DW = 16, IW = 4;
  localparam int NL = 1 << IW;

  logic clk = 0, rst = 1;
  logic bus_rd = 0, bus_wr = 0, mem_ack = 0, inval_all = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, mem_rdata = '0;
  logic ack_drv, ack_bus, rd_oe;
  logic [DW-1:0] rd_data;

  dm_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) i_dm_wt_cache (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .inval_all(inval_all), .ack_drv(ack_drv), .ack_bus(ack_bus),
    .rd_data(rd_data), .rd_oe(rd_oe));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] mem [1 << AW];
  bit            sv_valid [NL];
  int            sv_tag [NL];
  logic [DW-1:0] sv_data [NL];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_txn(input int a, input bit flush_on_fill);
    int  ix = a % NL;
    bit  exp_hit = sv_valid[ix] && sv_tag[ix] == a / NL;
    @(negedge clk);
    bus_rd = 1; bus_addr = AW'(a);
    @(negedge clk);
    if (exp_hit) begin
      chk(ack_drv == 1, "R3 hit ack after one edge", ack_drv, 1);
      chk(rd_oe == 1 && rd_data == sv_data[ix], "R9 hit data", rd_data, sv_data[ix]);
      @(negedge clk);
      chk(ack_drv == 1 && ack_bus == 1, "R3 ack held (R6 line)", ack_drv, 1);
      bus_rd = 0;
      #1 chk(ack_drv == 0 && rd_data == 0, "R3 ack drops with read", ack_drv, 0);
    end else begin
      chk(ack_drv == 0 && rd_oe == 0, "R4 miss no cache ack", ack_drv, 0);
      @(negedge clk);
      chk(ack_drv == 0 && ack_bus == 0, "R6 line idle during miss wait", ack_bus, 0);
      mem_ack = 1; mem_rdata = mem[a]; inval_all = flush_on_fill;
      #1 chk(ack_bus == 1 && ack_drv == 0, "R6 memory ack on line", ack_bus, 1);
      @(negedge clk);
      chk(ack_drv == 0, "R8 no ack after fill", ack_drv, 0);
      bus_rd = 0; mem_ack = 0; inval_all = 0;
      if (flush_on_fill) foreach (sv_valid[i]) sv_valid[i] = 0;
      else begin sv_valid[ix] = 1; sv_tag[ix] = a / NL; sv_data[ix] = mem[a]; end
    end
  endtask

  task automatic expect_hit(input int a, input bit h, input string req);
    int ix = a % NL;
    chk((sv_valid[ix] && sv_tag[ix] == a / NL) == h, req, !h, h);
    rd_txn(a, 0);
  endtask

  task automatic wr_txn(input int a, input logic [DW-1:0] d);
    int ix = a % NL;
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = d; mem_ack = 1;
    #1 chk(ack_drv == 0 && ack_bus == 1, "R5 write acked by memory only", ack_drv, 0);
    @(negedge clk);
    bus_wr = 0; mem_ack = 0;
    mem[a] = d;
    sv_valid[ix] = 1; sv_tag[ix] = a / NL; sv_data[ix] = d;
  endtask

  task automatic flush;
    @(negedge clk); inval_all = 1;
    @(negedge clk); inval_all = 0;
    foreach (sv_valid[i]) sv_valid[i] = 0;
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) mem[a] = DW'(a * 37 + 5);
    foreach (sv_valid[i]) sv_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(ack_drv == 0 && rd_oe == 0 && ack_bus == 0 && rd_data == 0,
        "R2 R6 reset state idle", ack_bus, 0);
    // R2: every line empty after reset
    for (int i = 0; i < NL; i++) expect_hit(i, 0, "R2 cold miss");
    // R4: filled lines now hit with memory word
    for (int i = 0; i < NL; i++) expect_hit(i, 1, "R4 hit after fill");
    // R1: conflicting tags evict each other
    for (int i = 0; i < NL; i += 3) begin
      expect_hit(i + NL, 0, "R1 other tag misses");
      expect_hit(i + NL, 1, "R1 new tag hits");
      expect_hit(i, 0, "R1 old tag evicted");
    end
    // R5: write sweep over every address with read back
    for (int a = 0; a < (1 << AW); a++) begin
      wr_txn(a, DW'(a ^ 16'h5a5a));
      expect_hit(a, 1, "R5 read after write hits");
    end
    // R7: invalidate all
    flush;
    for (int i = 0; i < NL; i++) expect_hit(i + 2 * NL, 0, "R7 miss after flush");
    // R7: flush wins over a fill in the same cycle
    rd_txn(7 + 5 * NL, 1);
    expect_hit(7 + 5 * NL, 0, "R7 flush beats fill");
    expect_hit(7 + 5 * NL, 1, "R4 refill after flush");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule